// File: doc/BRIEF.md
# Page-Mapped Flash Write Allocator

This block keeps the logical-to-physical page map for a small flash array. It also keeps one validity bit for each physical page, a live-page count for each erase block, and one open block with a write pointer for each of the two planes. A host write takes the next blank page of an open block, strictly in ascending page order. If the logical page was already mapped, its old physical page is marked as garbage and the old block's live count drops by one. Pages are never rewritten in place. A host read returns the mapped physical page, or an unmapped status. An erase command cleans one block and returns it to its plane's free-block queue.

Blocks with an even number sit in plane 0 and blocks with an odd number in plane 1. Successive writes alternate between the two planes, so that a pair of writes can be issued to both planes together. When a write uses the last page of a plane's open block, the next block is taken from that plane's free queue. The `gc_req` output is raised while either plane's free queue is short, so that a later collector can act. The per-block live counts are exported for a later victim selector.

A controller state machine runs each command through these states:

- `ST_IDLE`: the block accepts a command.
- `ST_WRITE`: one cycle of allocation and map update.
- `ST_READ`: one cycle of map lookup.
- `ST_SCAN`: one cycle per logical page, dropping map entries that point into the erased block.
- `ST_WIPE`: clears validity and handles the free queue and the write pointer.
- `ST_RESP`: a one-cycle response.

The transitions are:

- IDLE→WRITE, IDLE→READ and IDLE→SCAN on an accepted command.
- WRITE→RESP and READ→RESP.
- SCAN→SCAN until the last logical page, then SCAN→WIPE.
- WIPE→RESP.
- RESP→IDLE.

Top module: `pma_alloc`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` and `gc_req` are 0, every block's live count is 0 and every logical page reads as unmapped. Plane 0 has block 0 open and plane 1 has block 1 open, both at page 0. Each plane's free queue holds its remaining blocks in ascending order.
- R2: A physical page number is encoded as `block*PPB + page`. A write returns `rsp_ok`=1 and the page at the write pointer of the chosen plane's open block. Planes alternate on successive writes, starting with plane 0, so the first writes land on pages 0, 4, 1, 5 with the default parameters.
- R3: Within a block, pages are allocated in ascending order. No page is allocated twice between erases of its block.
- R4: Writing a logical page that is already mapped moves it to a fresh page. The old physical page loses its validity bit, and its block's live count in `blk_valid_cnt` (field `b` at bits `b*CW +: CW`) drops by one.
- R5: A read of a mapped logical page returns `rsp_ok`=1 with the current page. A read of an unmapped logical page returns `rsp_ok`=0 with `rsp_ppn`=0 and `rsp_sect`=0.
- R6: On every response, `rsp_sect` equals `rsp_ppn*SPP`, where SPP is the number of sectors per page: 8, 16 or 32.
- R7: When a write takes the last page of an open block, the plane opens the block at the head of its free queue. If that queue is empty, the plane closes.
- R8: A write goes to the other plane when the plane whose turn it is has no open block. If neither plane has an open block, the write returns `rsp_ok`=0 and changes nothing.
- R9: `gc_req` is 1 exactly while either plane's free queue holds fewer than GC_LOW blocks.
- R10: Erasing a block has these effects:
  - The block's live count becomes 0.
  - Every logical page mapped into the block becomes unmapped.
  - If the block is its plane's open block, the write pointer rewinds to 0.
  - If the plane has no open block, the erased block becomes its open block.
  - Otherwise the erased block is appended to the free queue, unless it is already queued.
  - The response is `rsp_ok`=1 with `rsp_ppn`=0.
- R11: `cmd_ready` is 1 only in the idle state. The response comes 2 cycles after acceptance for reads and writes, and LPAGES+2 cycles after acceptance for erases. The response lasts one cycle and is followed by the idle state.
- R12: Command codes are 1 for write, 2 for read and 3 for erase. An accepted command with code 0 is ignored: `cmd_ready` stays 1, there is no response, and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code (0 none, 1 write, 2 read, 3 erase) |
| cmd_lpn | input | LPW | Logical page for write or read |
| cmd_blk | input | BW | Block for erase |
| cmd_ready | output | 1 | Idle and accepting |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Write placed, read mapped, or erase done |
| rsp_ppn | output | PPNW | Physical page number |
| rsp_sect | output | PPNW+SW | First physical sector of that page |
| gc_req | output | 1 | A free queue is below the low-water mark |
| blk_valid_cnt | output | NBLK*CW | Live-page count for each block |

## Verification
The checker assumes that commands arrive only while `cmd_ready` is high and that the command fields are stable in the accepting cycle. It also assumes that reset is held for at least one clock. Given this, the allocation and invalidation properties rely on the state machine never allocating and erasing in the same cycle. The stimulus drives on the falling edge and raises `cmd_valid` only while `cmd_ready` is sampled high. Erase targets stay within the block range. The random phase mixes erases with writes, so open blocks get rewound, queues refill, and both planes can close.

// File: rtl/pma_pkg.sv
package pma_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_ERASE = 2'd3
    } pma_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_SCAN,
        ST_WIPE,
        ST_RESP
    } pma_state_e;

endpackage

// File: rtl/pma_free_fifo.sv
// Per-plane queue of erased blocks; reset preloads the plane's spare blocks.
module pma_free_fifo #(
    parameter int NBLK  = 8,
    parameter int PLANE = 0,
    localparam int DEPTH = NBLK / 2,
    localparam int BW    = $clog2(NBLK),
    localparam int IW    = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [BW-1:0]   push_blk,
    input  logic            pop,
    output logic [BW-1:0]   head,
    output logic [CNTW-1:0] level,
    output logic            empty
);

    logic [BW-1:0]   slot [DEPTH];
    logic [IW-1:0]   rd_ptr;
    logic [IW-1:0]   wr_ptr;
    logic [CNTW-1:0] fill;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot[k] <= BW'(PLANE + 2 * (k + 1));
            end
            rd_ptr <= '0;
            wr_ptr <= IW'(DEPTH - 1);
            fill   <= CNTW'(DEPTH - 1);
        end else begin
            if (push) begin
                slot[wr_ptr] <= push_blk;
                wr_ptr       <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            fill <= fill + CNTW'(push) - CNTW'(pop);
        end
    end

    assign head  = slot[rd_ptr];
    assign level = fill;
    assign empty = (fill == '0);

endmodule

// File: rtl/pma_valid_track.sv
// Per-page validity bits and per-block live counts.
module pma_valid_track #(
    parameter int NBLK = 8,
    parameter int PPB  = 4,
    localparam int NPP  = NBLK * PPB,
    localparam int BW   = $clog2(NBLK),
    localparam int PGW  = $clog2(PPB),
    localparam int PPNW = BW + PGW,
    localparam int CW   = $clog2(PPB + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [PPNW-1:0]    set_ppn,
    input  logic               clr_en,
    input  logic [PPNW-1:0]    clr_ppn,
    input  logic               wipe_en,
    input  logic [BW-1:0]      wipe_blk,
    output logic [NPP-1:0]     page_valid,
    output logic [NBLK*CW-1:0] cnt_flat
);

    for (genvar gb = 0; gb < NBLK; gb++) begin : g_blk
        logic [CW-1:0] cnt_q;
        logic          inc;
        logic          dec;
        logic          wipe_hit;

        assign inc      = set_en  && (set_ppn[PPNW-1:PGW] == BW'(gb));
        assign dec      = clr_en  && (clr_ppn[PPNW-1:PGW] == BW'(gb));
        assign wipe_hit = wipe_en && (wipe_blk == BW'(gb));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (wipe_hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(inc) - CW'(dec);
            end
        end

        assign cnt_flat[gb*CW +: CW] = cnt_q;

        for (genvar gp = 0; gp < PPB; gp++) begin : g_pg
            logic pv_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pv_q <= 1'b0;
                end else if (wipe_hit) begin
                    pv_q <= 1'b0;
                end else if (set_en && set_ppn == PPNW'(gb * PPB + gp)) begin
                    pv_q <= 1'b1;
                end else if (clr_en && clr_ppn == PPNW'(gb * PPB + gp)) begin
                    pv_q <= 1'b0;
                end
            end

            assign page_valid[gb*PPB + gp] = pv_q;
        end
    end

endmodule

// File: rtl/pma_l2p_map.sv
// Logical-to-physical page table with one lookup port.
module pma_l2p_map #(
    parameter int LPAGES = 16,
    parameter int PPNW   = 5,
    localparam int LPW = $clog2(LPAGES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [LPW-1:0]  wr_lpn,
    input  logic [PPNW-1:0] wr_ppn,
    input  logic            clr_en,
    input  logic [LPW-1:0]  clr_lpn,
    input  logic [LPW-1:0]  rd_lpn,
    output logic            rd_hit,
    output logic [PPNW-1:0] rd_ppn
);

    logic            ent_hit [LPAGES];
    logic [PPNW-1:0] ent_ppn [LPAGES];

    for (genvar g = 0; g < LPAGES; g++) begin : g_ent
        logic            hit_q;
        logic [PPNW-1:0] ppn_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q <= 1'b0;
                ppn_q <= '0;
            end else if (wr_en && wr_lpn == LPW'(g)) begin
                hit_q <= 1'b1;
                ppn_q <= wr_ppn;
            end else if (clr_en && clr_lpn == LPW'(g)) begin
                hit_q <= 1'b0;
            end
        end

        assign ent_hit[g] = hit_q;
        assign ent_ppn[g] = ppn_q;
    end

    assign rd_hit = ent_hit[rd_lpn];
    assign rd_ppn = ent_ppn[rd_lpn];

endmodule

// File: rtl/pma_alloc.sv
// Page-mapped write allocator: controller FSM, plane state, map, validity.
module pma_alloc
    import pma_pkg::*;
#(
    parameter int LPAGES = 16,
    parameter int NBLK   = 8,
    parameter int PPB    = 4,
    parameter int SPP    = 8,
    parameter int GC_LOW = 2,
    localparam int LPW  = $clog2(LPAGES),
    localparam int BW   = $clog2(NBLK),
    localparam int PGW  = $clog2(PPB),
    localparam int PPNW = BW + PGW,
    localparam int SW   = $clog2(SPP),
    localparam int CW   = $clog2(PPB + 1),
    localparam int NPP  = NBLK * PPB,
    localparam int FCW  = $clog2(NBLK / 2 + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [LPW-1:0]      cmd_lpn,
    input  logic [BW-1:0]       cmd_blk,
    output logic                cmd_ready,
    output logic                rsp_valid,
    output logic                rsp_ok,
    output logic [PPNW-1:0]     rsp_ppn,
    output logic [PPNW+SW-1:0]  rsp_sect,
    output logic                gc_req,
    output logic [NBLK*CW-1:0]  blk_valid_cnt
);

    localparam logic [PGW-1:0] LAST_PG = PGW'(PPB - 1);

    pma_state_e state_q, state_d;

    logic [LPW-1:0]  lpn_q;
    logic [BW-1:0]   blk_q;
    logic [LPW-1:0]  scan_q;
    logic            rsp_ok_q;
    logic [PPNW-1:0] rsp_ppn_q;
    logic            turn_q;
    logic [NBLK-1:0] blk_free_q;

    logic [BW-1:0]   open_blk [2];
    logic [PGW-1:0]  wp       [2];
    logic            open_ok  [2];

    logic [BW-1:0]   f_head  [2];
    logic [FCW-1:0]  f_level [2];
    logic            f_empty [2];
    logic            f_push  [2];
    logic            f_pop   [2];

    logic            any_open;
    logic            use_p;
    logic [PPNW-1:0] new_ppn;
    logic            er_plane;

    logic [LPW-1:0]  map_rd_lpn;
    logic            map_hit;
    logic [PPNW-1:0] map_ppn;
    logic            map_clr;

    logic            trk_set_en;
    logic [PPNW-1:0] trk_set_ppn;
    logic            trk_clr_en;
    logic [PPNW-1:0] trk_clr_ppn;
    logic            wipe_en;
    logic [NPP-1:0]  page_valid;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (pma_op_e'(cmd_op))
                        OP_WRITE: state_d = ST_WRITE;
                        OP_READ:  state_d = ST_READ;
                        OP_ERASE: state_d = ST_SCAN;
                        OP_NOP:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WRITE: state_d = ST_RESP;
            ST_READ:  state_d = ST_RESP;
            ST_SCAN:  state_d = (scan_q == LPW'(LPAGES - 1)) ? ST_WIPE : ST_SCAN;
            ST_WIPE:  state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_ok    = rsp_ok_q;
        rsp_ppn   = rsp_ppn_q;
        rsp_sect  = {rsp_ppn_q, {SW{1'b0}}};
        gc_req    = (f_level[0] < FCW'(GC_LOW)) || (f_level[1] < FCW'(GC_LOW));
    end

    // ---------------- allocation datapath ----------------
    assign any_open    = open_ok[0] | open_ok[1];
    assign use_p       = open_ok[turn_q] ? turn_q : ~turn_q;
    assign new_ppn     = {open_blk[use_p], wp[use_p]};
    assign er_plane    = blk_q[0];

    assign map_rd_lpn  = (state_q == ST_SCAN) ? scan_q : lpn_q;
    assign trk_set_en  = (state_q == ST_WRITE) && any_open;
    assign trk_set_ppn = new_ppn;
    assign trk_clr_en  = trk_set_en && map_hit;
    assign trk_clr_ppn = map_ppn;
    assign map_clr     = (state_q == ST_SCAN) && map_hit && (map_ppn[PPNW-1:PGW] == blk_q);
    assign wipe_en     = (state_q == ST_WIPE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lpn_q     <= '0;
            blk_q     <= '0;
            scan_q    <= '0;
            rsp_ok_q  <= 1'b0;
            rsp_ppn_q <= '0;
            turn_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && cmd_valid) begin
                lpn_q  <= cmd_lpn;
                blk_q  <= cmd_blk;
                scan_q <= '0;
            end
            if (state_q == ST_SCAN) begin
                scan_q <= scan_q + 1'b1;
            end
            if (state_q == ST_WRITE) begin
                rsp_ok_q  <= any_open;
                rsp_ppn_q <= any_open ? new_ppn : '0;
            end
            if (state_q == ST_READ) begin
                rsp_ok_q  <= map_hit;
                rsp_ppn_q <= map_hit ? map_ppn : '0;
            end
            if (wipe_en) begin
                rsp_ok_q  <= 1'b1;
                rsp_ppn_q <= '0;
            end
            if (trk_set_en) begin
                turn_q <= ~use_p;
            end
        end
    end

    // ---------------- per-plane open block and free queue ----------------
    for (genvar gp = 0; gp < 2; gp++) begin : g_plane
        logic [BW-1:0]  ob_q;
        logic [PGW-1:0] wp_q;
        logic           ok_q;
        logic           sel;
        logic           er_here;

        assign sel     = trk_set_en && (use_p == 1'(gp));
        assign er_here = wipe_en && (er_plane == 1'(gp));

        assign f_pop[gp]  = sel && (wp_q == LAST_PG) && !f_empty[gp];
        assign f_push[gp] = er_here && ok_q && (ob_q != blk_q) && !blk_free_q[blk_q];

        pma_free_fifo #(
            .NBLK  (NBLK),
            .PLANE (gp)
        ) u_free (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (f_push[gp]),
            .push_blk (blk_q),
            .pop      (f_pop[gp]),
            .head     (f_head[gp]),
            .level    (f_level[gp]),
            .empty    (f_empty[gp])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ob_q <= BW'(gp);
                wp_q <= '0;
                ok_q <= 1'b1;
            end else if (sel) begin
                if (wp_q == LAST_PG) begin
                    wp_q <= '0;
                    if (!f_empty[gp]) begin
                        ob_q <= f_head[gp];
                    end else begin
                        ok_q <= 1'b0;
                    end
                end else begin
                    wp_q <= wp_q + 1'b1;
                end
            end else if (er_here) begin
                if (!ok_q) begin
                    ob_q <= blk_q;
                    ok_q <= 1'b1;
                    wp_q <= '0;
                end else if (ob_q == blk_q) begin
                    wp_q <= '0;
                end
            end
        end

        assign open_blk[gp] = ob_q;
        assign wp[gp]       = wp_q;
        assign open_ok[gp]  = ok_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                blk_free_q[b] <= (b >= 2);
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (f_pop[p]) begin
                    blk_free_q[f_head[p]] <= 1'b0;
                end
                if (f_push[p]) begin
                    blk_free_q[blk_q] <= 1'b1;
                end
            end
        end
    end

    // ---------------- map and validity ----------------
    pma_l2p_map #(
        .LPAGES (LPAGES),
        .PPNW   (PPNW)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (trk_set_en),
        .wr_lpn  (lpn_q),
        .wr_ppn  (new_ppn),
        .clr_en  (map_clr),
        .clr_lpn (scan_q),
        .rd_lpn  (map_rd_lpn),
        .rd_hit  (map_hit),
        .rd_ppn  (map_ppn)
    );

    pma_valid_track #(
        .NBLK (NBLK),
        .PPB  (PPB)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (trk_set_en),
        .set_ppn    (trk_set_ppn),
        .clr_en     (trk_clr_en),
        .clr_ppn    (trk_clr_ppn),
        .wipe_en    (wipe_en),
        .wipe_blk   (blk_q),
        .page_valid (page_valid),
        .cnt_flat   (blk_valid_cnt)
    );

endmodule

// File: rtl/pma_chk.sv
module pma_chk #(
    parameter int NBLK = 8,
    parameter int PPB  = 4,
    parameter int SPP  = 8,
    localparam int BW   = $clog2(NBLK),
    localparam int PGW  = $clog2(PPB),
    localparam int PPNW = BW + PGW,
    localparam int SW   = $clog2(SPP),
    localparam int CW   = $clog2(PPB + 1),
    localparam int NPP  = NBLK * PPB
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic               cmd_ready,
    input logic               rsp_valid,
    input logic               rsp_ok,
    input logic [PPNW-1:0]    rsp_ppn,
    input logic [PPNW+SW-1:0] rsp_sect,
    input logic               set_en,
    input logic [PPNW-1:0]    set_ppn,
    input logic               clr_en,
    input logic [PPNW-1:0]    clr_ppn,
    input logic [NPP-1:0]     page_valid,
    input logic [NBLK*CW-1:0] cnt_flat
);

    // R3
    alloc_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !page_valid[set_ppn]);

    // R4
    inval_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> page_valid[clr_ppn]);

    // R5
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_ppn == '0));

    // R6
    sect_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_sect == (PPNW+SW)'(rsp_ppn) * (PPNW+SW)'(SPP)));

    // R11
    resp_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (cmd_ready && !rsp_valid));

    // R12
    nop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_op == 2'd0) |=> (cmd_ready && !rsp_valid));

    // R4
    always @(posedge clk) begin
        if (rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                cnt_match_chk: assert ($countones(page_valid[b*PPB +: PPB]) == int'(cnt_flat[b*CW +: CW]))
                    else $error("block %0d count mismatch", b);
            end
        end
    end

endmodule

bind pma_alloc pma_chk #(
    .NBLK (NBLK),
    .PPB  (PPB),
    .SPP  (SPP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_ppn    (rsp_ppn),
    .rsp_sect   (rsp_sect),
    .set_en     (trk_set_en),
    .set_ppn    (trk_set_ppn),
    .clr_en     (trk_clr_en),
    .clr_ppn    (trk_clr_ppn),
    .page_valid (page_valid),
    .cnt_flat   (blk_valid_cnt)
);

// File: tb/sim_pma_alloc.sv
module sim_pma_alloc;

    localparam int LPAGES = 16;
    localparam int NBLK   = 8;
    localparam int PPB    = 4;
    localparam int SPP    = 8;
    localparam int GC_LOW = 2;
    localparam int NPP    = NBLK * PPB;
    localparam int CW     = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [3:0]  cmd_lpn = '0;
    logic [2:0]  cmd_blk = '0;
    logic        cmd_ready;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [4:0]  rsp_ppn;
    logic [7:0]  rsp_sect;
    logic        gc_req;
    logic [NBLK*CW-1:0] blk_valid_cnt;

    always #10 clk = ~clk;

    pma_alloc #(
        .LPAGES (LPAGES), .NBLK (NBLK), .PPB (PPB), .SPP (SPP), .GC_LOW (GC_LOW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_lpn (cmd_lpn), .cmd_blk (cmd_blk), .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid), .rsp_ok (rsp_ok), .rsp_ppn (rsp_ppn),
        .rsp_sect (rsp_sect), .gc_req (gc_req), .blk_valid_cnt (blk_valid_cnt)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference model
    int mv [LPAGES];
    int mp [LPAGES];
    bit pv [NPP];
    bit prog [NPP];
    int cnt [NBLK];
    int ob [2];
    int wpm [2];
    bit ook [2];
    int turn;
    int fq0 [$];
    int fq1 [$];
    bit bfree [NBLK];
    int last_ok, last_ppn;

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < LPAGES; l++) begin mv[l] = 0; mp[l] = 0; end
        for (int p = 0; p < NPP; p++) begin pv[p] = 0; prog[p] = 0; end
        for (int b = 0; b < NBLK; b++) begin cnt[b] = 0; bfree[b] = (b >= 2); end
        ob[0] = 0; ob[1] = 1; wpm[0] = 0; wpm[1] = 0; ook[0] = 1; ook[1] = 1;
        turn = 0;
        fq0 = {};
        fq1 = {};
        for (int b = 2; b < NBLK; b++) begin
            if (b % 2 == 0) fq0.push_back(b); else fq1.push_back(b);
        end
    endtask

    function automatic bit exp_gc();
        return (fq0.size() < GC_LOW) || (fq1.size() < GC_LOW);
    endfunction

    // per-clock comparison of state visible at the ports
    task automatic compare_every();
        chk(gc_req == exp_gc(), "R9", "gc_req", int'(gc_req), int'(exp_gc()));
        for (int b = 0; b < NBLK; b++) begin
            chk(int'(blk_valid_cnt[b*CW +: CW]) == cnt[b], "R4", "live count",
                int'(blk_valid_cnt[b*CW +: CW]), cnt[b]);
        end
    endtask

    task automatic model_apply(input int op, input int lpn, input int blk,
                               output int ok, output int ppn);
        ok = 0; ppn = 0;
        if (op == 1) begin
            int p;
            if (ook[turn]) p = turn;
            else if (ook[1 - turn]) p = 1 - turn;
            else p = -1;
            if (p >= 0) begin
                ppn = ob[p] * PPB + wpm[p];
                ok = 1;
                chk(prog[ppn] == 0, "R3", "page reused before erase", ppn, -1);
                prog[ppn] = 1;
                if (mv[lpn]) begin
                    pv[mp[lpn]] = 0;
                    cnt[mp[lpn] / PPB]--;
                end
                mv[lpn] = 1; mp[lpn] = ppn; pv[ppn] = 1; cnt[ppn / PPB]++;
                wpm[p]++;
                if (wpm[p] == PPB) begin
                    wpm[p] = 0;
                    if (p == 0 && fq0.size() > 0) begin ob[0] = fq0.pop_front(); bfree[ob[0]] = 0; end
                    else if (p == 1 && fq1.size() > 0) begin ob[1] = fq1.pop_front(); bfree[ob[1]] = 0; end
                    else ook[p] = 0;
                end
                turn = 1 - p;
            end
        end else if (op == 2) begin
            if (mv[lpn]) begin ok = 1; ppn = mp[lpn]; end
        end else if (op == 3) begin
            int p;
            p = blk % 2;
            for (int l = 0; l < LPAGES; l++) begin
                if (mv[l] && mp[l] / PPB == blk) mv[l] = 0;
            end
            for (int g = 0; g < PPB; g++) begin
                pv[blk * PPB + g] = 0;
                prog[blk * PPB + g] = 0;
            end
            cnt[blk] = 0;
            if (!ook[p]) begin
                ob[p] = blk; ook[p] = 1; wpm[p] = 0;
            end else if (ob[p] == blk) begin
                wpm[p] = 0;
            end else if (!bfree[blk]) begin
                if (p == 0) fq0.push_back(blk); else fq1.push_back(blk);
                bfree[blk] = 1;
            end
            ok = 1;
        end
    endtask

    // issue one command starting at a falling edge; returns after the idle cycle
    task automatic do_cmd(input int op, input int lpn, input int blk);
        int cyc;
        int eok, eppn, elat;
        string rq;
        chk(cmd_ready == 1'b1, "R11", "ready before command", int'(cmd_ready), 1);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_lpn   = 4'(lpn);
        cmd_blk   = 3'(blk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 0) begin
            chk(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R12", "no-op ignored",
                int'(rsp_valid), 0);
            compare_every();
            return;
        end
        cyc = 1;
        while (!rsp_valid && cyc < 64) begin
            chk(cmd_ready == 1'b0, "R11", "ready while busy", int'(cmd_ready), 0);
            compare_every();
            @(negedge clk);
            cyc++;
        end
        model_apply(op, lpn, blk, eok, eppn);
        elat = (op == 3) ? LPAGES + 2 : 2;
        chk(rsp_valid == 1'b1 && cyc == elat, "R11", "response latency", cyc, elat);
        rq = (op == 1) ? (eok ? "R2" : "R8") : (op == 2) ? "R5" : "R10";
        chk(int'(rsp_ok) == eok, rq, "rsp_ok", int'(rsp_ok), eok);
        chk(int'(rsp_ppn) == eppn, rq, "rsp_ppn", int'(rsp_ppn), eppn);
        chk(int'(rsp_sect) == int'(rsp_ppn) * SPP, "R6", "rsp_sect",
            int'(rsp_sect), int'(rsp_ppn) * SPP);
        last_ok  = int'(rsp_ok);
        last_ppn = int'(rsp_ppn);
        compare_every();
        @(negedge clk);
        chk(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R11", "idle after response",
            int'(rsp_valid), 0);
        compare_every();
    endtask

    initial begin
        int rejected;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
        chk(gc_req == 1'b0, "R1", "gc_req after reset", int'(gc_req), 0);
        chk(blk_valid_cnt == '0, "R1", "counts after reset", int'(blk_valid_cnt), 0);
        do_cmd(2, 0, 0);
        chk(last_ok == 0, "R1", "lpn 0 unmapped", last_ok, 0);
        do_cmd(2, 15, 0);
        chk(last_ok == 0 && last_ppn == 0, "R5", "unmapped read", last_ppn, 0);

        // R12: no-op
        do_cmd(0, 3, 0);

        // R2: alternate planes from plane 0
        for (int l = 0; l < 8; l++) begin
            do_cmd(1, l, 0);
            if (l == 0) chk(last_ppn == 0, "R2", "first write page", last_ppn, 0);
            if (l == 1) chk(last_ppn == 4, "R2", "second write page", last_ppn, 4);
            if (l == 2) chk(last_ppn == 1, "R2", "third write page", last_ppn, 1);
        end
        // R7: plane 0 opens block 2 from its queue
        do_cmd(1, 8, 0);
        chk(last_ppn == 8, "R7", "next block opened", last_ppn, 8);

        // R4: overwrite lpn 0 moves it and invalidates old page in block 0
        do_cmd(1, 0, 0);
        chk(last_ppn == 12, "R4", "overwrite new page", last_ppn, 12);
        chk(int'(blk_valid_cnt[0 +: CW]) == 3, "R4", "block 0 count",
            int'(blk_valid_cnt[0 +: CW]), 3);
        do_cmd(2, 0, 0);
        chk(last_ok == 1 && last_ppn == 12, "R5", "read remapped", last_ppn, 12);

        // R10: erase block 1 unmaps its logical pages
        do_cmd(3, 0, 1);
        do_cmd(2, 1, 0);
        chk(last_ok == 0, "R10", "erased page unmapped", last_ok, 0);
        chk(int'(blk_valid_cnt[1*CW +: CW]) == 0, "R10", "erased count",
            int'(blk_valid_cnt[1*CW +: CW]), 0);

        // R8: fill until both planes close
        rejected = 0;
        for (int i = 0; i < 60 && !rejected; i++) begin
            do_cmd(1, i % LPAGES, 0);
            if (last_ok == 0) rejected = 1;
        end
        chk(rejected == 1, "R8", "write rejected when full", rejected, 1);
        chk(gc_req == 1'b1, "R9", "gc_req when queues empty", int'(gc_req), 1);
        do_cmd(3, 0, 0);
        do_cmd(1, 5, 0);
        chk(last_ok == 1 && last_ppn == 0, "R10", "erase reopens closed plane", last_ppn, 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 55)      do_cmd(1, $urandom_range(0, LPAGES - 1), 0);
            else if (r < 80) do_cmd(2, $urandom_range(0, LPAGES - 1), 0);
            else if (r < 93) do_cmd(3, 0, $urandom_range(0, NBLK - 1));
            else             do_cmd(0, $urandom_range(0, LPAGES - 1), 0);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule